// File: doc/BRIEF.md
# Precise Exception Status Tracker

This block follows every instruction of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) with a small record: a valid bit, a delay-slot flag, a vector of exception causes and a set of program counters. Each stage can add causes to the record of the instruction it currently holds. Exceptions may therefore be noticed out of program order, for example a young instruction's fetch fault before an older load's data fault. Each cause is still recorded against the instruction that raised it.

A record is examined only when it reaches writeback, so exceptions are served in program order, oldest first. An instruction that carries any cause may not write registers or memory. A store that sits behind a faulting instruction is also held back. When a faulting record reaches writeback, the block raises a trap request in that cycle. The pipeline's fetch unit uses that request to insert the trap instruction. In the same cycle the block reports the cause code and the saved program counters, which are the faulting PC and one more PC for each branch delay slot. At the following clock edge every younger instruction in flight is turned into a bubble, so that it can be restarted from scratch. The pipeline never stalls: a fetched instruction reaches writeback exactly four cycles after its fetch cycle.

Top module: `exc_status_pipe`

## Requirements
- R1: After reset, and after a reset in the middle of a run, the pipeline holds no instructions: trap_req, wb_reg_we_ok, mem_store_ok and trap_in_delay are 0, and trap_code and trap_pcs are 0.
- R2: trap_code encodes the reported cause as follows. 0 is a fetch page fault (if_fault bit 0). 1 is a fetch misaligned access (if_fault bit 1). 2 is a fetch protection violation (if_fault bit 2). 3 is an illegal opcode (id_illegal). 4 is an arithmetic exception (ex_arith). 5 is a data page fault (mem_fault bit 0). 6 is a data misaligned access (mem_fault bit 1). 7 is a data protection violation (mem_fault bit 2).
- R3: When one instruction carries several causes, the trap reports the lowest code among them. This is the cause from the earliest stage, and within a stage the lowest bit.
- R4: An instruction fetched in cycle t with any cause has trap_req high in cycle t+4, while it is in writeback. trap_req is low whenever writeback holds no faulting instruction.
- R5: When an older instruction faults in a later stage than a younger one, the older instruction's cause is reported first. The younger instruction's cause is discarded by the flush and raises no trap.
- R6: wb_reg_we_ok is high only for a valid writeback instruction with no cause. mem_store_ok is high only for a valid memory-stage instruction with no cause, counting a mem_fault raised in the same cycle, and only when writeback holds no faulting instruction.
- R7: During a trap, bits [PC_W-1:0] of trap_pcs hold the faulting instruction's PC. Slice k holds the PC of the k-th accepted fetch before it, for k up to DELAY_SLOTS. trap_in_delay repeats the if_in_delay flag that the instruction was fetched with.
- R8: At the clock edge that ends a trap cycle, all instructions in decode, execute, memory and writeback are dropped, and so is the fetch presented in the trap cycle. In the next cycle there is no trap, no register write and no store.
- R9: Exception inputs for a stage that holds no instruction, including if_fault with if_valid low, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| if_valid | input | 1 | An instruction is fetched this cycle |
| if_pc | input | PC_W | PC of the fetched instruction |
| if_in_delay | input | 1 | Fetched instruction sits in a branch delay slot |
| if_fault | input | 3 | Fetch causes: bit0 page fault, bit1 misaligned, bit2 protection |
| id_illegal | input | 1 | Decode stage instruction has an illegal opcode |
| ex_arith | input | 1 | Execute stage instruction raised an arithmetic exception |
| mem_fault | input | 3 | Data causes: bit0 page fault, bit1 misaligned, bit2 protection |
| wb_reg_we_ok | output | 1 | Writeback instruction may write the register file |
| mem_store_ok | output | 1 | Memory-stage instruction may write memory |
| trap_req | output | 1 | Take a trap now; fetch the trap instruction next |
| trap_code | output | 3 | Encoded cause of the trap |
| trap_pcs | output | (DELAY_SLOTS+1)*PC_W | Saved PCs, faulting PC in the lowest slice |
| trap_in_delay | output | 1 | Faulting instruction was in a delay slot |

## Verification
The checks assume that the pipeline upstream never stalls, so an instruction fetched with if_valid high reaches writeback exactly four cycles later. The properties that compare trap_pcs and trap_req against values of if_pc and if_valid four cycles earlier depend on this. The bench moves one step per clock and never holds an instruction back. It raises each stage's exception input only in the cycle when the targeted instruction is in that stage. In some cycles it deliberately drives exception inputs at stages that are empty, to show that they are ignored.

// File: rtl/exc_track_pkg.sv
package exc_track_pkg;
    localparam int CAUSE_N = 8;
    localparam int CODE_W  = $clog2(CAUSE_N);
    localparam int IF_N    = 3;
    localparam int MEM_N   = 3;
    // bit positions in the per-instruction cause vector; lower index = earlier stage
    localparam int BIT_ILLEGAL = IF_N;
    localparam int BIT_ARITH   = IF_N + 1;
    localparam int BIT_MEM_LO  = IF_N + 2;

    typedef logic [CAUSE_N-1:0] cause_vec_t;
endpackage

// File: rtl/exc_cause_prio.sv
module exc_cause_prio #(
    parameter int N = 8,
    parameter int W = 3
) (
    input  logic [N-1:0] vec,
    output logic [W-1:0] code
);
    always_comb begin
        code = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) code = W'(i);
        end
    end
endmodule

// File: rtl/exc_pc_hist.sv
module exc_pc_hist #(
    parameter int PC_W  = 32,
    parameter int DEPTH = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [PC_W-1:0]            pc,
    output logic [DEPTH:0][PC_W-1:0]   pcs
);
    generate
        if (DEPTH == 0) begin : g_none
            assign pcs[0] = pc;
        end else begin : g_hist
            logic [DEPTH-1:0][PC_W-1:0] hist_d, hist_q;

            always_comb begin
                hist_d = hist_q;
                if (push) begin
                    for (int k = DEPTH - 1; k > 0; k--) hist_d[k] = hist_q[k-1];
                    hist_d[0] = pc;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) hist_q <= '0;
                else        hist_q <= hist_d;
            end

            assign pcs = {hist_q, pc};
        end
    endgenerate
endmodule

// File: rtl/exc_status_pipe.sv
module exc_status_pipe
    import exc_track_pkg::*;
#(
    parameter int PC_W        = 32,
    parameter int DELAY_SLOTS = 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                if_valid,
    input  logic [PC_W-1:0]                     if_pc,
    input  logic                                if_in_delay,
    input  logic [IF_N-1:0]                     if_fault,
    input  logic                                id_illegal,
    input  logic                                ex_arith,
    input  logic [MEM_N-1:0]                    mem_fault,
    output logic                                wb_reg_we_ok,
    output logic                                mem_store_ok,
    output logic                                trap_req,
    output logic [CODE_W-1:0]                   trap_code,
    output logic [(DELAY_SLOTS+1)*PC_W-1:0]     trap_pcs,
    output logic                                trap_in_delay
);
    localparam int NPC = DELAY_SLOTS + 1;

    typedef struct packed {
        logic                      vld;
        logic                      dly;
        cause_vec_t                cv;
        logic [NPC-1:0][PC_W-1:0]  pcs;
    } ent_t;

    typedef struct packed {
        ent_t id;
        ent_t ex;
        ent_t mem;
        ent_t wb;
    } pipe_t;

    pipe_t st_d, st_q;
    logic [NPC-1:0][PC_W-1:0] fetch_pcs;
    logic [CODE_W-1:0]        wb_code;
    cause_vec_t               mem_cv_now;
    logic                     trap_now;

    assign trap_now = st_q.wb.vld & (|st_q.wb.cv);

    exc_pc_hist #(.PC_W(PC_W), .DEPTH(DELAY_SLOTS)) u_hist (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (if_valid & ~trap_now),
        .pc    (if_pc),
        .pcs   (fetch_pcs)
    );

    exc_cause_prio #(.N(CAUSE_N), .W(CODE_W)) u_prio (
        .vec  (st_q.wb.cv),
        .code (wb_code)
    );

    always_comb begin
        mem_cv_now = st_q.mem.cv;
        if (st_q.mem.vld) mem_cv_now[BIT_MEM_LO +: MEM_N] = st_q.mem.cv[BIT_MEM_LO +: MEM_N] | mem_fault;
    end

    always_comb begin
        st_d = st_q;

        // fetch: new record, fetch causes land in the low bits
        st_d.id.vld = if_valid;
        st_d.id.dly = if_valid & if_in_delay;
        st_d.id.cv  = '0;
        if (if_valid) st_d.id.cv[IF_N-1:0] = if_fault;
        st_d.id.pcs = fetch_pcs;

        // decode -> execute
        st_d.ex = st_q.id;
        st_d.ex.cv[BIT_ILLEGAL] = st_q.id.cv[BIT_ILLEGAL] | (st_q.id.vld & id_illegal);

        // execute -> memory
        st_d.mem = st_q.ex;
        st_d.mem.cv[BIT_ARITH] = st_q.ex.cv[BIT_ARITH] | (st_q.ex.vld & ex_arith);

        // memory -> writeback
        st_d.wb    = st_q.mem;
        st_d.wb.cv = mem_cv_now;

        // trap taken: every younger instruction becomes a bubble
        if (trap_now) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trap_req      = trap_now;
    assign wb_reg_we_ok  = st_q.wb.vld & ~(|st_q.wb.cv);
    assign mem_store_ok  = st_q.mem.vld & ~(|mem_cv_now) & ~trap_now;
    assign trap_code     = trap_now ? wb_code : '0;
    assign trap_pcs      = trap_now ? st_q.wb.pcs : '0;
    assign trap_in_delay = trap_now & st_q.wb.dly;
endmodule

// File: rtl/exc_status_chk.sv
module exc_status_chk #(
    parameter int PC_W        = 32,
    parameter int DELAY_SLOTS = 1
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             if_valid,
    input logic [PC_W-1:0]                  if_pc,
    input logic [2:0]                       mem_fault,
    input logic                             wb_reg_we_ok,
    input logic                             mem_store_ok,
    input logic                             trap_req,
    input logic [(DELAY_SLOTS+1)*PC_W-1:0]  trap_pcs
);
    AST_TRAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> !trap_req); // R8

    AST_FLUSH_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> !mem_store_ok); // R8

    AST_WB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_req && wb_reg_we_ok)); // R6

    AST_STORE_BEHIND_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> !mem_store_ok); // R6

    AST_STORE_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|mem_fault) |-> !mem_store_ok); // R6

    AST_TRAP_AGE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $past(if_valid, 4)); // R4

    AST_EPC_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (trap_pcs[PC_W-1:0] == $past(if_pc, 4))); // R7
endmodule

bind exc_status_pipe exc_status_chk #(.PC_W(PC_W), .DELAY_SLOTS(DELAY_SLOTS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .if_valid     (if_valid),
    .if_pc        (if_pc),
    .mem_fault    (mem_fault),
    .wb_reg_we_ok (wb_reg_we_ok),
    .mem_store_ok (mem_store_ok),
    .trap_req     (trap_req),
    .trap_pcs     (trap_pcs)
);

// File: tb/exc_status_pipe_test.sv
module exc_status_pipe_test;
    localparam int CLK_P = 10;
    localparam int PC_W  = 32;
    localparam int DS    = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic if_valid = 1'b0;
    logic [PC_W-1:0] if_pc = '0;
    logic if_in_delay = 1'b0;
    logic [2:0] if_fault = '0;
    logic id_illegal = 1'b0;
    logic ex_arith = 1'b0;
    logic [2:0] mem_fault = '0;
    logic wb_reg_we_ok, mem_store_ok, trap_req, trap_in_delay;
    logic [2:0] trap_code;
    logic [(DS+1)*PC_W-1:0] trap_pcs;

    int checks = 0;
    int fails  = 0;

    always #(CLK_P/2) clk = ~clk;

    exc_status_pipe #(.PC_W(PC_W), .DELAY_SLOTS(DS)) uut (
        .clk(clk), .rst_n(rst_n), .if_valid(if_valid), .if_pc(if_pc),
        .if_in_delay(if_in_delay), .if_fault(if_fault), .id_illegal(id_illegal),
        .ex_arith(ex_arith), .mem_fault(mem_fault), .wb_reg_we_ok(wb_reg_we_ok),
        .mem_store_ok(mem_store_ok), .trap_req(trap_req), .trap_code(trap_code),
        .trap_pcs(trap_pcs), .trap_in_delay(trap_in_delay)
    );

    // stage: 0 fetch, 1 decode, 2 execute, 3 memory
    typedef struct packed {
        logic [1:0]  stage;
        logic [2:0]  bits;
        logic        dly;
        logic [2:0]  code;
        logic [31:0] pc;
    } vec_t;

    localparam vec_t TBL [8] = '{
        '{2'd0, 3'b001, 1'b0, 3'd0, 32'h0000_1000},
        '{2'd0, 3'b100, 1'b0, 3'd2, 32'h0000_2000},
        '{2'd0, 3'b110, 1'b0, 3'd1, 32'h0000_3000},
        '{2'd1, 3'b001, 1'b0, 3'd3, 32'h0000_4000},
        '{2'd2, 3'b001, 1'b0, 3'd4, 32'h0000_5000},
        '{2'd3, 3'b001, 1'b0, 3'd5, 32'h0000_6000},
        '{2'd3, 3'b010, 1'b0, 3'd6, 32'h0000_7000},
        '{2'd3, 3'b100, 1'b1, 3'd7, 32'h0000_8000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic iv, input logic [31:0] pc, input logic dly,
                       input logic [2:0] ifx, input logic idx, input logic exx,
                       input logic [2:0] mx);
        @(negedge clk);
        if_valid = iv; if_pc = pc; if_in_delay = dly; if_fault = ifx;
        id_illegal = idx; ex_arith = exx; mem_fault = mx;
        #1;
    endtask

    // one clean lead instruction E at base-4, then faulting A at base, then younger ones
    task automatic run_case(input logic [31:0] base, input logic dly,
                            input logic [2:0] ifx, input logic idx, input logic exx,
                            input logic [2:0] mx, input logic [2:0] code, input string tag);
        cyc(1, base - 4, 0, 0, 0, 0, 0);
        cyc(1, base, dly, ifx, 0, 0, 0);
        cyc(1, base + 4, 0, 0, idx, 0, 0);
        cyc(1, base + 8, 0, 0, 0, exx, 0);
        chk({tag, " R6 clean store allowed"}, 32'(mem_store_ok), 1);
        cyc(1, base + 12, 0, 0, 0, 0, mx);
        chk({tag, " R6 faulting store blocked"}, 32'(mem_store_ok), 0);
        chk({tag, " R6 clean writeback"}, 32'(wb_reg_we_ok), 1);
        cyc(1, base + 16, 0, 0, 0, 0, 0);
        chk({tag, " R4 trap at wb"}, 32'(trap_req), 1);
        chk({tag, " R2 R3 cause code"}, 32'(trap_code), 32'(code));
        chk({tag, " R7 epc0"}, trap_pcs[31:0], base);
        chk({tag, " R7 epc1"}, trap_pcs[63:32], base - 4);
        chk({tag, " R7 delay flag"}, 32'(trap_in_delay), 32'(dly));
        chk({tag, " R6 younger store blocked"}, 32'(mem_store_ok), 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        chk({tag, " R8 no trap after flush"}, 32'(trap_req), 0);
        chk({tag, " R8 no write after flush"}, 32'(wb_reg_we_ok | mem_store_ok), 0);
        repeat (3) cyc(0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin : watchdog
        #(CLK_P * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset trap", 32'(trap_req), 0);
        chk("R1 reset writes", 32'(wb_reg_we_ok | mem_store_ok), 0);
        chk("R1 reset pcs", trap_pcs[31:0] | trap_pcs[63:32], 0);
        rst_n = 1'b1;

        // table walk: one cause per entry
        for (int i = 0; i < 8; i++) begin
            vec_t v;
            v = TBL[i];
            run_case(v.pc, v.dly,
                     (v.stage == 2'd0) ? v.bits : 3'b000,
                     (v.stage == 2'd1),
                     (v.stage == 2'd2),
                     (v.stage == 2'd3) ? v.bits : 3'b000,
                     v.code, $sformatf("vec%0d", i));
        end

        // R3: fetch fault and data fault on one instruction -> fetch code 0
        run_case(32'h0000_9000, 0, 3'b001, 0, 0, 3'b001, 3'd0, "multi_if_mem");
        // R3: illegal opcode and arithmetic on one instruction -> 3
        run_case(32'h0000_A000, 0, 3'b000, 1, 1, 3'b000, 3'd3, "multi_id_ex");

        // R5: younger B faults at fetch before older A faults at memory
        cyc(1, 32'h0000_B000, 0, 0, 0, 0, 0);
        cyc(1, 32'h0000_B004, 0, 3'b001, 0, 0, 0);
        cyc(1, 32'h0000_B008, 0, 0, 0, 0, 0);
        cyc(1, 32'h0000_B00C, 0, 0, 0, 0, 3'b001);
        cyc(0, 0, 0, 0, 0, 0, 0);
        chk("R5 older trap first", 32'(trap_req), 1);
        chk("R5 older cause", 32'(trap_code), 5);
        chk("R5 older pc", trap_pcs[31:0], 32'h0000_B000);
        cyc(0, 0, 0, 0, 0, 0, 0);
        chk("R5 younger discarded", 32'(trap_req), 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        chk("R5 younger discarded later", 32'(trap_req), 0);

        // R9: exception inputs on empty stages
        for (int k = 0; k < 5; k++) begin
            cyc(0, 32'h0000_C000, 1, 3'b111, 1, 1, 3'b111);
            chk("R9 empty stage store", 32'(mem_store_ok), 0);
        end
        cyc(0, 0, 0, 0, 0, 0, 0);
        chk("R9 no trap from empty stages", 32'(trap_req), 0);
        cyc(1, 32'h0000_D000, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 3'b111, 0, 1, 3'b111);
        cyc(0, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        chk("R9 clean instr retires", 32'(wb_reg_we_ok), 1);
        chk("R9 clean instr no trap", 32'(trap_req), 0);

        // R1: reset in mid-flight drops a faulting instruction
        cyc(1, 32'h0000_E000, 0, 3'b001, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        rst_n = 1'b0;
        cyc(0, 0, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            cyc(0, 0, 0, 0, 0, 0, 0);
            chk("R1 mid reset no trap", 32'(trap_req), 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule